// File: doc/BRIEF.md
# Infrared Envelope Sampler with Carrier Detection

The block watches the output of an infrared receiver, one sample per clock cycle. It first decides whether the incoming burst rides on a carrier by timing the first rising-edge spacing and the first low stretch against a programmable threshold. When a carrier is found, it measures one carrier period and presents it on an output register.

At the same time it removes the carrier and writes the resulting envelope to a ring buffer as 16-bit words. Bit 15 of each word gives the level and bits 14:0 give the duration. Words go out through a byte-wide write port, high byte first, at the ring entry that follows the exposed pointer.

Host software reads the ring and corrects the stored widths by the threshold: it subtracts the threshold from a high width and adds it to a low width. Clearing the enable stops capture and discards any segment in progress, but keeps the pointer. A one-cycle init pulse returns the pointer to entry zero.

Top module: `ir_envelope_sampler`

## Requirements
- R1: After synchronous reset, `car_period` is 0, `wr_ptr` is 0 and `wr_en` is 0.
- R2: If the first low stretch after the first rising edge is longer than `det_time` cycles, the input is judged unmodulated and `car_period` stays 0.
- R3: If the first two rising edges are `det_time` or more cycles apart, the input is judged unmodulated and `car_period` stays 0.
- R4: If the first two rising edges are fewer than `det_time` cycles apart, `car_period` is loaded with the number of cycles between the third and fourth rising edges, and it holds that value while `en` stays high.
- R5: If a carrier was judged present but a low stretch longer than `det_time` arrives before the fourth rising edge, `car_period` stays 0.
- R6: The first word after enabling is a high word (bit 15 = 1). A high word closes on the cycle where a low stretch first exceeds `det_time`. Its count equals the number of cycles from the segment's first rising edge to the end of its last high level, plus `det_time`. No word has a zero count.
- R7: A low word (bit 15 = 0) closes on the next rising edge. Its count is the low gap minus `det_time`. Closed words alternate in level.
- R8: A segment longer than 0x7FFF cycles is written as a word with count 0x7FFF, then continues from a fresh count as further words of the same level.
- R9: Each word is written as two bytes on consecutive cycles: bits 15:8 at an even offset, then bits 7:0 at that offset plus one.
- R10: A word goes to ring offset `wr_ptr`+2 (modulo 256 for 128 entries). After its low byte, `wr_ptr` moves to that offset, so it wraps from 0xFE to 0x00.
- R11: While `en` is low, `car_period` reads 0, no bytes are written, any partial segment is dropped and `wr_ptr` keeps its value. After `en` rises again, capture starts at the next rising edge.
- R12: An `init` pulse sets `wr_ptr` to 0, so the next word lands at offset 0x02.
- R13: While enabled and before the first rising edge, a low input of any length produces no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable; low clears the counters and the carrier decision |
| init | input | 1 | One-cycle pulse that returns the ring pointer to 0 |
| det_time | input | THR_W | Detecting-time threshold in cycles |
| ir_in | input | 1 | Asynchronous infrared receiver signal, high = light |
| car_period | output | THR_W | Measured carrier period in cycles, 0 when there is no carrier |
| wr_en | output | 1 | Ring byte write strobe |
| wr_addr | output | PTR_W | Ring byte offset being written |
| wr_data | output | 8 | Ring byte being written |
| wr_ptr | output | PTR_W | Offset of the high byte of the latest complete word |

## Verification
The queue-depth assertion assumes `det_time` is at least 2. At that value, two words never arrive faster than the two-cycle byte writer can drain them. The assertions also assume that `det_time` changes only while `en` is low, that `init` is pulsed only while no word is pending, and that `ir_in` is low during reset. The stimulus sets every threshold to 2 or more and reprograms it only with `en` low. It pulses `init` only after capture has stopped, and it holds the receiver input low whenever reset or a threshold change is in progress.

// File: rtl/ir_smp_pkg.sv
`timescale 1ns/1ps
package ir_smp_pkg;

    // Envelope word: level flag on top, duration below.
    localparam int REC_W   = 16;
    localparam int CNT_W   = REC_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } env_rec_t;

    typedef enum logic [2:0] {
        CD_IDLE,
        CD_FIRST,
        CD_WAIT3,
        CD_MEAS,
        CD_DONE
    } cd_state_t;

    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
        return (c == CNT_MAX) ? CNT_MAX : c + 1'b1;
    endfunction

endpackage

// File: rtl/ir_sync_edge.sv
`timescale 1ns/1ps
module ir_sync_edge #(
    parameter int SYNC_STAGES = 2,
    parameter int THR_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ir_in,
    output logic             rise,
    output logic [THR_W-1:0] lo_len
);
    localparam logic [THR_W-1:0] RUN_MAX = '1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   lvl_d;
    logic [THR_W-1:0]       lo_run;

    assign lvl  = sync_q[SYNC_STAGES-1];
    assign rise = lvl & ~lvl_d;

    // Length of the low run including the current cycle, 0 while high.
    always_comb begin
        if (lvl)
            lo_len = '0;
        else if (lo_run == RUN_MAX)
            lo_len = RUN_MAX;
        else
            lo_len = lo_run + 1'b1;
    end

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ir_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d  <= 1'b0;
            lo_run <= '0;
        end else begin
            lvl_d  <= lvl;
            lo_run <= lo_len;
        end
    end

endmodule

// File: rtl/ir_carrier_det.sv
`timescale 1ns/1ps
module ir_carrier_det
    import ir_smp_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rise,
    input  logic [THR_W-1:0] lo_len,
    input  logic [THR_W-1:0] det_time,
    output logic [THR_W-1:0] car_period
);
    localparam logic [THR_W-1:0] INTV_MAX = '1;

    cd_state_t        state;
    logic [THR_W-1:0] intv;
    logic [THR_W-1:0] intv_nx;
    logic             gap_seen;

    assign intv_nx  = (intv == INTV_MAX) ? INTV_MAX : intv + 1'b1;
    assign gap_seen = lo_len > det_time;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state      <= CD_IDLE;
            intv       <= '0;
            car_period <= '0;
        end else begin
            intv <= intv_nx;
            unique case (state)
                CD_IDLE: begin
                    if (rise) begin
                        state <= CD_FIRST;
                        intv  <= THR_W'(1);
                    end
                end
                CD_FIRST: begin
                    if (rise)
                        state <= (intv < det_time) ? CD_WAIT3 : CD_DONE;
                    else if (gap_seen)
                        state <= CD_DONE;
                end
                CD_WAIT3: begin
                    if (rise) begin
                        state <= CD_MEAS;
                        intv  <= THR_W'(1);
                    end else if (gap_seen) begin
                        state <= CD_DONE;
                    end
                end
                CD_MEAS: begin
                    if (rise) begin
                        car_period <= intv;
                        state      <= CD_DONE;
                    end else if (gap_seen) begin
                        state <= CD_DONE;
                    end
                end
                default: state <= CD_DONE;
            endcase
        end
    end

    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> car_period == '0); // R11

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && car_period != '0) |=> (!en || car_period == $past(car_period))); // R4

endmodule

// File: rtl/ir_env_logger.sv
`timescale 1ns/1ps
module ir_env_logger
    import ir_smp_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rise,
    input  logic [THR_W-1:0] lo_len,
    input  logic [THR_W-1:0] det_time,
    output logic             rec_vld,
    output env_rec_t         rec
);
    logic             active;
    logic             lvl;
    logic [CNT_W-1:0] cnt;
    logic             close_hi;
    logic             close_lo;
    logic             split;

    assign close_hi = active &  lvl & (lo_len > det_time);
    assign close_lo = active & ~lvl & rise;
    assign split    = active & (cnt == CNT_MAX) & ~close_hi & ~close_lo;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active  <= 1'b0;
            lvl     <= 1'b0;
            cnt     <= '0;
            rec_vld <= 1'b0;
            rec     <= '0;
        end else begin
            rec_vld <= 1'b0;
            if (!active) begin
                if (rise) begin
                    active <= 1'b1;
                    lvl    <= 1'b1;
                    cnt    <= CNT_W'(1);
                end
            end else if (close_hi || close_lo || split) begin
                rec_vld <= 1'b1;
                rec     <= '{lvl: lvl, cnt: cnt};
                cnt     <= CNT_W'(1);
                if (!split) lvl <= ~lvl;
            end else begin
                cnt <= cnt_step(cnt);
            end
        end
    end

    // Tracking of the previous word for the ordering checks below.
    logic prev_lvl;
    logic prev_split;
    logic have_prev;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            prev_lvl   <= 1'b0;
            prev_split <= 1'b0;
            have_prev  <= 1'b0;
        end else if (rec_vld) begin
            prev_lvl   <= rec.lvl;
            prev_split <= (rec.cnt == CNT_MAX);
            have_prev  <= 1'b1;
        end
    end

    AST_SEG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rec_vld |-> rec.cnt != '0); // R6

    AST_FIRST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (rec_vld && !have_prev) |-> rec.lvl); // R6

    AST_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (rec_vld && have_prev && !prev_split) |-> rec.lvl != prev_lvl); // R7

    AST_SPLIT_SAME: assert property (@(posedge clk) disable iff (rst)
        (rec_vld && have_prev && prev_split) |-> rec.lvl == prev_lvl); // R8

endmodule

// File: rtl/ir_ring_writer.sv
`timescale 1ns/1ps
module ir_ring_writer
    import ir_smp_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             rec_vld,
    input  env_rec_t         rec,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] wr_ptr
);
    env_rec_t         q0;
    env_rec_t         q1;
    logic [1:0]       fill;
    logic             phase;
    logic             pop;
    logic [1:0]       fill_left;
    logic [REC_W-1:0] head;

    assign head      = q0;
    assign pop       = phase && (fill != 2'd0);
    assign fill_left = fill - {1'b0, pop};

    always_ff @(posedge clk) begin
        if (rst || init) begin
            q0      <= '0;
            q1      <= '0;
            fill    <= 2'd0;
            phase   <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_ptr  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (fill != 2'd0) begin
                wr_en   <= 1'b1;
                wr_addr <= {wr_ptr[PTR_W-1:1] + 1'b1, phase};
                wr_data <= phase ? head[7:0] : head[15:8];
                phase   <= ~phase;
                if (phase) wr_ptr <= wr_ptr + PTR_W'(2);
            end
            if (pop) q0 <= q1;
            if (rec_vld) begin
                if (fill_left == 2'd0) q0 <= rec;
                else                   q1 <= rec;
            end
            fill <= fill_left + {1'b0, rec_vld};
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst || init)
        rec_vld |-> fill_left < 2'd2); // R10

    AST_BYTE_PAIR: assert property (@(posedge clk) disable iff (rst || init)
        (wr_en && !wr_addr[0]) |=> (wr_en && wr_addr[0])); // R9

    AST_ADDR_AHEAD: assert property (@(posedge clk) disable iff (rst || init)
        (wr_en && !wr_addr[0]) |-> wr_addr[PTR_W-1:1] == wr_ptr[PTR_W-1:1] + 1'b1); // R10

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst || init)
        (!$past(rst) && !$past(init) && wr_ptr != $past(wr_ptr))
            |-> wr_ptr == $past(wr_ptr) + PTR_W'(2)); // R10

endmodule

// File: rtl/ir_envelope_sampler.sv
`timescale 1ns/1ps
module ir_envelope_sampler
    import ir_smp_pkg::*;
#(
    parameter  int THR_W        = 16,
    parameter  int RING_ENTRIES = 128,
    parameter  int SYNC_STAGES  = 2,
    localparam int PTR_W        = $clog2(2 * RING_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             init,
    input  logic [THR_W-1:0] det_time,
    input  logic             ir_in,
    output logic [THR_W-1:0] car_period,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] wr_ptr
);
    logic             rise;
    logic [THR_W-1:0] lo_len;
    logic             rec_vld;
    env_rec_t         rec;

    ir_sync_edge #(.SYNC_STAGES(SYNC_STAGES), .THR_W(THR_W)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .ir_in  (ir_in),
        .rise   (rise),
        .lo_len (lo_len)
    );

    ir_carrier_det #(.THR_W(THR_W)) i_carrier (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .rise       (rise),
        .lo_len     (lo_len),
        .det_time   (det_time),
        .car_period (car_period)
    );

    ir_env_logger #(.THR_W(THR_W)) i_logger (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .rise     (rise),
        .lo_len   (lo_len),
        .det_time (det_time),
        .rec_vld  (rec_vld),
        .rec      (rec)
    );

    ir_ring_writer #(.PTR_W(PTR_W)) i_ring (
        .clk     (clk),
        .rst     (rst),
        .init    (init),
        .rec_vld (rec_vld),
        .rec     (rec),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ptr  (wr_ptr)
    );

endmodule

// File: tb/test_ir_envelope_sampler.sv
`timescale 1ns/1ps
module test_ir_envelope_sampler;

    localparam int THR_W = 16;
    localparam int PTR_W = 8;
    localparam int LOGN  = 1024;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             init = 1'b0;
    logic             ir = 1'b0;
    logic [THR_W-1:0] det = 16'd20;
    logic [THR_W-1:0] car_period;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [PTR_W-1:0] wr_ptr;

    ir_envelope_sampler i_ir_envelope_sampler (
        .clk(clk), .rst(rst), .en(en), .init(init), .det_time(det), .ir_in(ir),
        .car_period(car_period), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ptr(wr_ptr)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] log_d [LOGN];
    logic [7:0] log_a [LOGN];
    int nbytes = 0;

    always @(negedge clk) begin
        if (!rst && wr_en && nbytes < LOGN) begin
            log_d[nbytes] <= wr_data;
            log_a[nbytes] <= wr_addr;
            nbytes        <= nbytes + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int word_at(input int k);
        return int'({log_d[2*k], log_d[2*k+1]});
    endfunction

    task automatic drv(input bit v, input int n);
        ir = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // det, high, low, pulses, gap, expected period, expected high count, expected low word
    localparam int NV = 6;
    localparam int VEC [NV][8] = '{
        '{20, 4, 6,  8, 60, 10,  94, 40},
        '{30, 5, 8, 12, 50, 13, 178, 20},
        '{20, 30, 0, 1, 45,  0,  50, 25},
        '{20, 25, 5, 3, 40,  0, 105, 20},
        '{20, 3, 5,  2, 40,  0,  31, 20},
        '{ 6, 2, 2,  5, 15,  4,  24,  9}
    };
    localparam string VREQ [NV] = '{"R4", "R4", "R2", "R3", "R5", "R4"};

    initial begin
        int r0;
        int p0;
        int bad;
        int badord;

        idle(4);
        rst = 1'b0;
        idle(1);
        chk("R1", "reset car_period", int'(car_period), 0);
        chk("R1", "reset wr_ptr", int'(wr_ptr), 0);
        chk("R1", "reset wr_en", int'(wr_en), 0);

        for (int v = 0; v < NV; v++) begin
            r0 = nbytes / 2;
            en = 1'b0;
            idle(3);
            det = THR_W'(VEC[v][0]);
            en = 1'b1;
            drv(1'b0, 5);
            for (int p = 0; p < VEC[v][3]; p++) begin
                drv(1'b1, VEC[v][1]);
                drv(1'b0, (p == VEC[v][3] - 1) ? VEC[v][4] : VEC[v][2]);
            end
            drv(1'b1, VEC[v][0] + 12);
            chk(VREQ[v], $sformatf("vector %0d car_period", v), int'(car_period), VEC[v][5]);
            chk("R6", $sformatf("vector %0d high word", v), word_at(r0), 32'h8000 | VEC[v][6]);
            chk("R7", $sformatf("vector %0d low word", v), word_at(r0 + 1), VEC[v][7]);
            chk("R6", $sformatf("vector %0d word count", v), nbytes / 2 - r0, 2);
            chk("R9", $sformatf("vector %0d byte order", v),
                int'(log_a[2*r0+1]), int'(log_a[2*r0] + 8'd1));
            chk("R10", $sformatf("vector %0d pointer", v), int'(wr_ptr), int'(log_a[2*r0+2]));
            en = 1'b0;
            ir = 1'b0;
        end

        // R11: disable mid-segment, then restart; R13: low before first rise is ignored
        idle(3);
        p0 = int'(wr_ptr);
        r0 = nbytes / 2;
        det = 16'd20;
        en = 1'b1;
        drv(1'b0, 5);
        drv(1'b1, 50);
        en = 1'b0;
        idle(10);
        chk("R11", "no writes after disable", nbytes / 2, r0);
        chk("R11", "car_period cleared", int'(car_period), 0);
        chk("R11", "pointer kept", int'(wr_ptr), p0);
        en = 1'b1;
        drv(1'b1, 10);
        drv(1'b0, 40);
        chk("R13", "no writes before first rise", nbytes / 2, r0);
        drv(1'b1, 10);
        drv(1'b0, 40);
        drv(1'b1, 30);
        chk("R11", "restart high word", word_at(r0), 32'h801E);
        chk("R11", "restart low word", word_at(r0 + 1), 32'h0014);
        en = 1'b0;
        ir = 1'b0;

        // R8: long high segment split at 0x7FFF
        idle(3);
        r0 = nbytes / 2;
        en = 1'b1;
        drv(1'b0, 5);
        drv(1'b1, 33000);
        drv(1'b0, 100);
        drv(1'b1, 30);
        chk("R8", "saturated word", word_at(r0), 32'hFFFF);
        chk("R8", "remainder word", word_at(r0 + 1), 32'h80FD);
        chk("R7", "low after split", word_at(r0 + 2), 32'h0050);
        chk("R8", "split word count", nbytes / 2 - r0, 3);
        en = 1'b0;
        ir = 1'b0;

        // R12 and ring wrap R10
        idle(3);
        init = 1'b1;
        idle(1);
        init = 1'b0;
        chk("R12", "pointer after init", int'(wr_ptr), 0);
        r0 = nbytes / 2;
        det = 16'd2;
        en = 1'b1;
        drv(1'b0, 5);
        for (int p = 0; p < 70; p++) begin
            drv(1'b1, 3);
            drv(1'b0, 5);
        end
        drv(1'b1, 30);
        chk("R10", "ring word count", nbytes / 2 - r0, 140);
        chk("R12", "first offset after init", int'(log_a[2*r0]), 2);
        chk("R10", "word 128 wraps to offset 0", int'(log_a[2*(r0+127)]), 0);
        chk("R10", "final pointer", int'(wr_ptr), 8'h18);
        bad = 0;
        badord = 0;
        for (int k = 0; k < 140; k++) begin
            if (word_at(r0 + k) != ((k % 2 == 0) ? 32'h8005 : 32'h0003)) bad++;
            if (log_a[2*(r0+k)+1] != log_a[2*(r0+k)] + 8'd1 || log_a[2*(r0+k)][0]) badord++;
        end
        chk("R6", "ring word values mismatches", bad, 0);
        chk("R9", "ring byte order mismatches", badord, 0);
        en = 1'b0;
        ir = 1'b0;
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule